// File: doc/BRIEF.md
# Eight-input programmable interrupt controller core

This block gathers up to eight interrupt request lines. It resolves them by fixed priority and presents a single interrupt output to a processor. Software reaches it through two addresses. The command address carries the start-of-configuration word and end-of-interrupt commands. The data address carries the rest of the configuration sequence and then the interrupt mask. After configuration the block captures requests on edges or by level. It tracks which requests are being serviced, so that only a more urgent request can interrupt a running handler. On each acknowledge it returns a vector equal to a programmable base plus the input number.

The block can run alone, or as one of several controllers in a cascade. A cascade master does not return a vector for an input that carries a slave. Instead it names that input, so the slave can answer. A slave answers an acknowledge only when the named input equals its own identity. The role is taken from the last configuration word when buffered operation is selected. Otherwise it comes from a strap pin. End of interrupt is either commanded by software or automatic at acknowledge time.

Top module: `pic8_core`

## Requirements
- R1: After reset the interrupt output and both result strobes are low. A data-port read returns 0xFF and a command-port read returns 0x00. Data writes are ignored until a configuration sequence has been started.
- R2: A command write with bit 4 set starts configuration. Bit 0 of that word asks for a fourth word, bit 1 selects single (non-cascaded) use, and bit 3 selects level capture. This word clears the mask to 0x00, the in-service set and all pending requests. The interrupt output stays low until the sequence completes.
- R3: Data writes following that word are taken in order: the vector base; then the slave word, only when cascaded; then the fourth word, only when requested. The next data write after the sequence loads the mask.
- R4: In the running state a data write loads the mask, where a 1 disables the input. A data read returns the mask. With mask 0xFF the interrupt output stays low. An edge captured while masked raises the output once the bit is cleared.
- R5: In edge mode a rising input sets its pending bit, and the acknowledge that grants it clears the bit. A line held high does not request again until it falls and rises.
- R6: In level mode the pending bit follows the input one clock later. A request that falls before acknowledge is withdrawn, and acknowledge does not clear it.
- R7: Input 0 has the highest priority and input 7 the lowest. In the clock after an acknowledge pulse, the vector strobe is high and the vector is base plus the number of the highest-priority granted input.
- R8: The interrupt output is high only when some unmasked pending input has a higher priority than every input in service. Granting an input sets its in-service bit.
- R9: The command value 0x20 (bits 7..5 = 001, bits 4..3 = 00) clears the highest-priority in-service bit. A command-port read returns the in-service set, with bit n for input n.
- R10: When bit 1 of the fourth word is set (automatic end of interrupt), acknowledge grants the input without setting any in-service bit.
- R11: An acknowledge with no grantable request returns base plus 7 and changes no state.
- R12: A master is either buffered (fourth word bit 3) with bit 2 set, or unbuffered with the strap pin high. When it grants an input whose bit is set in the slave word, the clock after the acknowledge shows the cascade strobe with that input number and no vector strobe. The in-service bit is still set.
- R13: A slave is either buffered with fourth-word bit 2 clear, or unbuffered with the strap low. It acts on an acknowledge only when the cascade select input equals bits 2..0 of its slave word. Any other acknowledge gives no strobe and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the command address, 1 the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: in-service set at address 0, mask at address 1 |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-clock acknowledge pulse |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | Vector strobe, one clock after acknowledge |
| cas_sel_out | output | 3 | Input number handed to a slave (master role) |
| cas_valid | output | 1 | Cascade strobe, one clock after acknowledge |
| cas_sel_in | input | 3 | Selected slave number seen by a slave |
| master_strap | input | 1 | Role selection when buffered operation is off |

## Verification
The hardest situation to reach is nested service. A lower-priority input must be waiting behind an in-service bit, while a higher-priority input pre-empts it and is itself ended first. The stimulus grants input 1 while input 6 is also pending, then raises input 0 and grants it. Two end-of-interrupt commands then peel the in-service set back down one bit at a time, and the bench watches the output stay low, rise again, and finally release input 6. The cascade roles need their own configuration sequences. For a slave, a wrong select value is tried before the right one, so the ignored acknowledge can be seen to leave the request and the in-service set untouched.

// File: rtl/pic8_pkg.sv
// Shared types for the interrupt controller core.
package pic8_pkg;
    // Configuration sequence position.
    typedef enum logic [2:0] {
        ST_UNCONF = 3'd0,
        ST_W2     = 3'd1,
        ST_W3     = 3'd2,
        ST_W4     = 3'd3,
        ST_RUN    = 3'd4
    } cfg_state_t;

    // Mode bits collected from the configuration words.
    typedef struct packed {
        logic single;
        logic need4;
        logic level;
        logic aeoi;
        logic buffered;
        logic role_bit;
    } pic_cfg_t;
endpackage

// File: rtl/pic8_cfg.sv
// Configuration sequencer and mask register.
// Assumes addr 0 is the command address and addr 1 the data address.
// Data writes are ignored before the first start word.
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int NIN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 addr,
    input  logic [NIN-1:0]       wdata,
    output cfg_state_t           state,
    output pic_cfg_t             cfg,
    output logic [NIN-1:0]       base,
    output logic [NIN-1:0]       slave_word,
    output logic [NIN-1:0]       mask,
    output logic                 init_pulse
);
    // A command write with bit 4 set begins a new sequence.
    assign init_pulse = wr_en && !addr && wdata[4];

    // Walk the configuration words, then load the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_UNCONF;
            cfg        <= '0;
            base       <= '0;
            slave_word <= '0;
            mask       <= '1;
        end else if (init_pulse) begin
            state         <= ST_W2;
            cfg.need4     <= wdata[0];
            cfg.single    <= wdata[1];
            cfg.level     <= wdata[3];
            cfg.aeoi      <= 1'b0;
            cfg.buffered  <= 1'b0;
            cfg.role_bit  <= 1'b0;
            mask          <= '0;
        end else if (wr_en && addr) begin
            case (state)
                ST_W2: begin
                    base <= wdata;
                    if (!cfg.single)    state <= ST_W3;
                    else if (cfg.need4) state <= ST_W4;
                    else                state <= ST_RUN;
                end
                ST_W3: begin
                    slave_word <= wdata;
                    state      <= cfg.need4 ? ST_W4 : ST_RUN;
                end
                ST_W4: begin
                    cfg.aeoi     <= wdata[1];
                    cfg.role_bit <= wdata[2];
                    cfg.buffered <= wdata[3];
                    state        <= ST_RUN;
                end
                ST_RUN:  mask <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic8_capture.sv
// Request capture: rising-edge latch or registered level per input.
// Assumes irq_in is already synchronous to clk.
module pic8_capture #(
    parameter int NIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           level,
    input  logic           init_clr,
    input  logic [NIN-1:0] ack_clr,
    input  logic [NIN-1:0] irq_in,
    output logic [NIN-1:0] pend
);
    logic [NIN-1:0] prev;

    // Track previous line levels and update pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= irq_in;
            if (init_clr)   pend <= '0;
            else if (level) pend <= irq_in;
            else            pend <= (pend & ~ack_clr) | (irq_in & ~prev);
        end
    end
endmodule

// File: rtl/pic8_resolve.sv
// Fixed-priority resolver, index 0 most urgent. A pending unmasked input
// competes only if no in-service bit at its own or a more urgent index.
module pic8_resolve #(
    parameter int NIN = 8,
    localparam int IW = $clog2(NIN)
) (
    input  logic [NIN-1:0] pend,
    input  logic [NIN-1:0] mask,
    input  logic [NIN-1:0] isr,
    output logic           req_any,
    output logic [IW-1:0]  req_idx,
    output logic           isr_any,
    output logic [IW-1:0]  isr_idx
);
    logic [NIN-1:0] isr_pre;
    logic [NIN-1:0] allowed;

    // Prefix OR of the in-service set from the most urgent end.
    for (genvar g = 0; g < NIN; g++) begin : g_pre
        if (g == 0) begin : g_first
            assign isr_pre[g] = isr[g];
        end else begin : g_rest
            assign isr_pre[g] = isr_pre[g-1] | isr[g];
        end
    end

    assign allowed = pend & ~mask & ~isr_pre;
    assign req_any = |allowed;
    assign isr_any = |isr;

    // Pick the lowest set index of the grantable and in-service sets.
    always_comb begin
        req_idx = '0;
        isr_idx = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (allowed[i]) req_idx = IW'(i);
            if (isr[i])     isr_idx = IW'(i);
        end
    end
endmodule

// File: rtl/pic8_core.sv
// Eight-input interrupt controller top: in-service tracking, acknowledge
// handling, end-of-interrupt commands and cascade roles. Assumes inta is
// a single-clock pulse; results appear one clock later.
module pic8_core
    import pic8_pkg::*;
#(
    parameter int NIN = 8,
    localparam int IW = $clog2(NIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           addr,
    input  logic [NIN-1:0] wdata,
    output logic [NIN-1:0] rdata,
    input  logic [NIN-1:0] irq_in,
    output logic           int_out,
    input  logic           inta,
    output logic [NIN-1:0] vec_out,
    output logic           vec_valid,
    output logic [IW-1:0]  cas_sel_out,
    output logic           cas_valid,
    input  logic [IW-1:0]  cas_sel_in,
    input  logic           master_strap
);
    localparam logic [NIN-1:0] LAST_IDX = NIN'(NIN - 1);

    cfg_state_t     state;
    pic_cfg_t       cfg;
    logic [NIN-1:0] base, slave_word, mask, pend, isr, isr_nxt, ack_clr;
    logic           init_pulse, req_any, isr_any, run, is_master;
    logic           selected, ack_go, eoi_cmd, aeoi_on;
    logic [IW-1:0]  req_idx, isr_idx;

    pic8_cfg #(.NIN(NIN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .state(state), .cfg(cfg), .base(base), .slave_word(slave_word),
        .mask(mask), .init_pulse(init_pulse)
    );

    pic8_capture #(.NIN(NIN)) u_cap (
        .clk(clk), .rst_n(rst_n), .level(cfg.level), .init_clr(init_pulse),
        .ack_clr(ack_clr), .irq_in(irq_in), .pend(pend)
    );

    pic8_resolve #(.NIN(NIN)) u_res (
        .pend(pend), .mask(mask), .isr(isr), .req_any(req_any),
        .req_idx(req_idx), .isr_any(isr_any), .isr_idx(isr_idx)
    );

    // Role, acknowledge acceptance and command decode.
    assign run       = (state == ST_RUN);
    assign aeoi_on   = cfg.aeoi;
    assign is_master = cfg.buffered ? cfg.role_bit : master_strap;
    assign selected  = cfg.single || is_master || (cas_sel_in == slave_word[IW-1:0]);
    assign ack_go    = inta && run && selected;
    assign ack_clr   = (ack_go && req_any) ? (NIN'(1) << req_idx) : '0;
    assign eoi_cmd   = run && wr_en && !addr && (wdata[7:5] == 3'b001) && (wdata[4:3] == 2'b00);
    assign int_out   = run && req_any;
    assign rdata     = addr ? mask : isr;

    // Next in-service set: end of interrupt clears, a grant sets.
    always_comb begin
        isr_nxt = isr;
        if (eoi_cmd && isr_any)              isr_nxt[isr_idx] = 1'b0;
        if (ack_go && req_any && !cfg.aeoi)  isr_nxt[req_idx] = 1'b1;
    end

    // Hold the in-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) isr <= '0;
        else                      isr <= isr_nxt;
    end

    // Produce the vector or the cascade hand-off one clock after acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out     <= '0;
            vec_valid   <= 1'b0;
            cas_sel_out <= '0;
            cas_valid   <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            cas_valid <= 1'b0;
            if (ack_go) begin
                if (!req_any) begin
                    vec_out   <= base + LAST_IDX;
                    vec_valid <= 1'b1;
                end else if (!cfg.single && is_master && slave_word[req_idx]) begin
                    cas_sel_out <= req_idx;
                    cas_valid   <= 1'b1;
                end else begin
                    vec_out   <= base + {{(NIN-IW){1'b0}}, req_idx};
                    vec_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// Checker for the controller top, attached with the bind below.
module pic8_core_chk #(
    parameter int NIN = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           inta,
    input logic           int_out,
    input logic           vec_valid,
    input logic           cas_valid,
    input logic [NIN-1:0] mask,
    input logic [NIN-1:0] isr,
    input logic           run,
    input logic           aeoi_on,
    input logic           eoi_cmd,
    input logic           ack_go
);
    AST_RESULT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid || cas_valid) |-> $past(inta)); // R7
    AST_QUIET_UNTIL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !int_out); // R2
    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !int_out); // R4
    AST_AUTO_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && aeoi_on) |-> (isr == '0)); // R10
    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && !ack_go && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R9
    AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && cas_valid)); // R12
endmodule

bind pic8_core pic8_core_chk #(.NIN(NIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
    .vec_valid(vec_valid), .cas_valid(cas_valid), .mask(mask), .isr(isr),
    .run(run), .aeoi_on(aeoi_on), .eoi_cmd(eoi_cmd), .ack_go(ack_go)
);

// File: tb/pic8_core_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: acknowledge tasks queue expected vectors, a monitor
// pops and compares them whenever the vector strobe appears.
module pic8_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       inta = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [2:0] cas_sel_out;
    logic       cas_valid;
    logic [2:0] cas_sel_in = '0;
    logic       master_strap = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    pic8_core u_pic8_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
        .vec_out(vec_out), .vec_valid(vec_valid), .cas_sel_out(cas_sel_out),
        .cas_valid(cas_valid), .cas_sel_in(cas_sel_in), .master_strap(master_strap)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic ack_vec(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        inta = 1'b1;
        tick(1);
        inta = 1'b0;
    endtask

    task automatic ack_quiet(input string tag);
        inta = 1'b1;
        tick(1);
        inta = 1'b0;
        chk({tag, " no vector strobe"}, vec_valid, 1'b0);
        chk({tag, " no cascade strobe"}, cas_valid, 1'b0);
    endtask

    // Monitor: compare each produced vector with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7 unexpected vector actual=%0h expected=none", vec_out);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, vec_out, e);
            end
        end
    end

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 int_out", int_out, 1'b0);
        chk("R1 vec_valid", vec_valid, 1'b0);
        rd(1'b1, v); chk("R1 mask", v, 8'hFF);
        rd(1'b0, v); chk("R1 isr", v, 8'h00);
        wr(1'b1, 8'h12); rd(1'b1, v); chk("R1 data write before start ignored", v, 8'hFF);

        // R3 single, no fourth word: third data write is the mask
        wr(1'b0, 8'h12); rd(1'b1, v); chk("R2 start clears mask", v, 8'h00);
        wr(1'b1, 8'h80); wr(1'b1, 8'hAA);
        rd(1'b1, v); chk("R3 short sequence then mask", v, 8'hAA);

        // R3 single with fourth word, base 0x40
        wr(1'b0, 8'h13); wr(1'b1, 8'h40);
        irq_in[5] = 1'b1; tick(2);
        chk("R2 int low mid-sequence", int_out, 1'b0);
        wr(1'b1, 8'h01);
        chk("R3 run after fourth word", int_out, 1'b1);
        wr(1'b1, 8'h0F); rd(1'b1, v); chk("R3 mask after fourth word", v, 8'h0F);
        wr(1'b1, 8'h00);
        ack_vec(8'h45, "R3 vector base+5");
        wr(1'b0, 8'h20); irq_in = '0; tick(1);

        // R4 full mask blocks, captured edge appears on unmask
        wr(1'b1, 8'hFF);
        irq_in[2] = 1'b1; tick(2);
        chk("R4 full mask int low", int_out, 1'b0);
        wr(1'b1, 8'hFB); #1;
        chk("R4 unmask raises int", int_out, 1'b1);
        ack_vec(8'h42, "R4 vector base+2");
        chk("R8 in-service blocks same input", int_out, 1'b0);
        wr(1'b0, 8'h20); irq_in = '0; wr(1'b1, 8'h00);

        // R7/R8/R9 nesting
        irq_in = 8'b0100_0010; tick(1);
        chk("R7 int on two requests", int_out, 1'b1);
        ack_vec(8'h41, "R7 priority picks input 1");
        chk("R8 lower request waits", int_out, 1'b0);
        irq_in[0] = 1'b1; tick(1);
        chk("R8 higher request pre-empts", int_out, 1'b1);
        ack_vec(8'h40, "R7 vector base+0");
        rd(1'b0, v); chk("R9 isr nested", v, 8'h03);
        wr(1'b0, 8'h20); rd(1'b0, v); chk("R9 eoi clears bit 0", v, 8'h02);
        chk("R8 input 6 still blocked", int_out, 1'b0);
        wr(1'b0, 8'h20); rd(1'b0, v); chk("R9 eoi clears bit 1", v, 8'h00);
        chk("R8 input 6 released", int_out, 1'b1);
        ack_vec(8'h46, "R7 vector base+6");
        wr(1'b0, 8'h20);

        // R5 held lines do not re-request; a new rise does
        tick(2);
        chk("R5 held level no request", int_out, 1'b0);
        irq_in[1] = 1'b0; tick(1); irq_in[1] = 1'b1; tick(1);
        chk("R5 new rise requests", int_out, 1'b1);
        ack_vec(8'h41, "R5 vector base+1");
        wr(1'b0, 8'h20); irq_in = '0; tick(2);

        // R11 spurious acknowledge
        ack_vec(8'h47, "R11 spurious base+7");
        rd(1'b0, v); chk("R11 isr unchanged", v, 8'h00);
        chk("R11 int low", int_out, 1'b0);

        // R6 level capture, base 0x20
        wr(1'b0, 8'h1B); wr(1'b1, 8'h20); wr(1'b1, 8'h01);
        irq_in[4] = 1'b1; tick(1);
        chk("R6 level request", int_out, 1'b1);
        irq_in[4] = 1'b0; tick(1);
        chk("R6 level withdrawn", int_out, 1'b0);
        irq_in[4] = 1'b1; tick(1);
        ack_vec(8'h24, "R6 vector base+4");
        rd(1'b0, v); chk("R6 isr set", v, 8'h10);
        wr(1'b0, 8'h20);
        chk("R6 level still requesting after eoi", int_out, 1'b1);
        irq_in = '0; tick(1);

        // R10 automatic end of interrupt, base 0x60
        wr(1'b0, 8'h13); wr(1'b1, 8'h60); wr(1'b1, 8'h03);
        irq_in[3] = 1'b1; tick(1);
        ack_vec(8'h63, "R10 vector base+3");
        rd(1'b0, v); chk("R10 isr stays empty", v, 8'h00);
        chk("R10 int low after grant", int_out, 1'b0);
        irq_in = '0; tick(1);

        // R12 cascade master, slave on input 2, base 0x08
        wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h0D);
        irq_in[2] = 1'b1; tick(1);
        chk("R12 int on slave input", int_out, 1'b1);
        inta = 1'b1; tick(1); inta = 1'b0;
        chk("R12 cascade strobe", cas_valid, 1'b1);
        chk("R12 cascade number", cas_sel_out, 3'd2);
        chk("R12 no vector strobe", vec_valid, 1'b0);
        rd(1'b0, v); chk("R12 isr bit 2", v, 8'h04);
        irq_in[0] = 1'b1; tick(1);
        ack_vec(8'h08, "R12 local input vector base+0");
        wr(1'b0, 8'h20); wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R9 isr empty after two eoi", v, 8'h00);
        irq_in = '0; tick(1);

        // R13 slave with identity 2, strap selects slave, base 0x70
        master_strap = 1'b0;
        wr(1'b0, 8'h11); wr(1'b1, 8'h70); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
        irq_in[5] = 1'b1; tick(1);
        cas_sel_in = 3'd3;
        ack_quiet("R13 wrong select");
        rd(1'b0, v); chk("R13 isr unchanged", v, 8'h00);
        chk("R13 request kept", int_out, 1'b1);
        cas_sel_in = 3'd2;
        ack_vec(8'h75, "R13 addressed vector base+5");
        rd(1'b0, v); chk("R13 isr bit 5", v, 8'h20);
        irq_in = '0; tick(3);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 missing vectors actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule